// File: doc/BRIEF.md
# Cascadable Shift-and-Hold Output Driver Register

This block is a serial-in, parallel-out register for low-side output drivers. A serial bit stream is clocked into a shift chain by a slow serial clock pin. A separate register clock pin copies the whole chain into a storage word, and that word switches the driver channels. Each bit of `sink_on_o` is a logical "channel sinks current" flag. All five control and data pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the edges of the two clock pins are turned into one-cycle events.

Several blocks can be chained by feeding `ser_dout_o` into the next block's `ser_din_i`, with the clock, clear and blanking pins shared. The cascade output moves only on the falling serial-clock edge. This gives the next stage half a serial period of extra hold time. An active-low clear wipes the shift chain, the storage word and the cascade output. A blanking pin turns every channel off without touching the stored word.

Top module: `chain_drive_reg`

## Requirements
- R1: On each detected rising edge of `ser_clk_i`, stage 0 of the shift chain takes `ser_din_i` and stage i takes stage i-1. Word bit i is stage i, so a byte sent most-significant bit first ends up equal to itself.
- R2: On each detected rising edge of `reg_clk_i`, the storage word copies all WIDTH stages at once. Otherwise the storage word holds.
- R3: While the synchronised `clr_n_i` is low, the shift chain, the storage word and `ser_dout_o` are forced to 0. This wins over any serial-clock or register-clock edge detected in the same cycle.
- R4: While the synchronised `blank_i` is high, every bit of `sink_on_o` is 0. The storage word is kept, and it reappears when blanking ends.
- R5: While the synchronised `blank_i` is low, `sink_on_o[i]` equals storage bit i. A 1 means the channel is on.
- R6: `ser_dout_o` carries the last stage (WIDTH-1) and changes only on a detected falling edge of `ser_clk_i` (or on clear or reset). It does not change on the rising edge.
- R7: When rising edges of `ser_clk_i` and `reg_clk_i` are detected in the same cycle, the storage word takes the chain value from before that shift.
- R8: The first bit shifted in reaches `ser_dout_o` on the falling edge that follows the WIDTH-th rising edge. In a two-block chain that is fed 2×WIDTH bits, the downstream block holds the first WIDTH bits and the upstream block holds the last WIDTH bits.
- R9: Synchronous reset `rst` has the same effect as clear: outputs 0, and the chain and storage are empty. Synchronisers come out of reset with blanking active and clear inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock pin |
| reg_clk_i | input | 1 | Asynchronous register (latch) clock pin |
| clr_n_i | input | 1 | Asynchronous active-low clear of all registers |
| blank_i | input | 1 | Asynchronous active-high output blanking |
| ser_din_i | input | 1 | Serial data in |
| sink_on_o | output | WIDTH | Per-channel sink-enable flags |
| ser_dout_o | output | 1 | Cascade serial output, last stage, falling-edge timed |

## Verification
Two situations are hard to reach from the pins: a serial-clock edge and a register-clock edge landing in the same system cycle, and a clear landing on top of both. The bench gets there by changing the pins at the same falling system-clock edge. The pins then pass through identical synchroniser depths and become events in one cycle. The half-period cascade timing is observed through two chained instances. The bench checks `ser_dout_o` while the serial clock is high and again after it falls. It then checks that each instance stores the expected half of a 16-bit stream.

// File: rtl/chain_drive_pkg.sv
package chain_drive_pkg;

    localparam int DFLT_WIDTH = 8;

    // level-only pins
    typedef struct packed {
        logic din;
        logic clr_n;
        logic blank;
    } lvl_pins_t;

    // pins whose edges are events
    typedef struct packed {
        logic ser;
        logic rgs;
    } clk_pins_t;

    localparam lvl_pins_t LVL_RST = '{din: 1'b0, clr_n: 1'b1, blank: 1'b1};
    localparam clk_pins_t CLK_RST = '{ser: 1'b0, rgs: 1'b0};

    function automatic logic is_rise(input logic chg, input logic lvl);
        return chg & lvl;
    endfunction

    function automatic logic is_fall(input logic chg, input logic lvl);
        return chg & ~lvl;
    endfunction

endpackage

// File: rtl/cdr_sync2.sv
module cdr_sync2 #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= RST_VAL[g];
                    stab_q <= RST_VAL[g];
                end else begin
                    meta_q <= raw_i[g];
                    stab_q <= meta_q;
                end
            end
            assign lvl_o[g] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/cdr_edge_det.sv
module cdr_edge_det #(
    parameter int           N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl_i;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign chg_o[g] = lvl_i[g] ^ prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/cdr_shift_chain.sv
module cdr_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             step,
    input  logic             emit,
    input  logic             din,
    output logic [WIDTH-1:0] chain_q,
    output logic             dout_q
);
    localparam int LAST = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            chain_q <= '0;
        end else if (step) begin
            chain_q <= {chain_q[LAST-1:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            dout_q <= 1'b0;
        end else if (emit) begin
            dout_q <= chain_q[LAST];
        end
    end
endmodule

// File: rtl/cdr_store_gate.sv
module cdr_store_gate #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             load,
    input  logic             blank,
    input  logic [WIDTH-1:0] chain_i,
    output logic [WIDTH-1:0] store_q,
    output logic [WIDTH-1:0] sink_o
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            store_q <= '0;
        end else if (load) begin
            store_q <= chain_i;
        end
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_chan
            assign sink_o[g] = store_q[g] & ~blank;
        end
    endgenerate
endmodule

// File: rtl/chain_drive_reg.sv
module chain_drive_reg
    import chain_drive_pkg::*;
#(
    parameter int WIDTH = DFLT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             reg_clk_i,
    input  logic             clr_n_i,
    input  logic             blank_i,
    input  logic             ser_din_i,
    output logic [WIDTH-1:0] sink_on_o,
    output logic             ser_dout_o
);
    localparam int NLVL = $bits(lvl_pins_t);
    localparam int NCLK = $bits(clk_pins_t);

    lvl_pins_t lvl_raw, lvl_s;
    clk_pins_t clk_raw, clk_s, clk_chg;

    logic             ser_rise, ser_fall, reg_rise, wipe;
    logic [WIDTH-1:0] shift_q, store_q;

    assign lvl_raw = '{din: ser_din_i, clr_n: clr_n_i, blank: blank_i};
    assign clk_raw = '{ser: ser_clk_i, rgs: reg_clk_i};

    cdr_sync2 #(.N(NLVL), .RST_VAL(LVL_RST)) u_lvl_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (lvl_raw),
        .lvl_o (lvl_s)
    );

    cdr_sync2 #(.N(NCLK), .RST_VAL(CLK_RST)) u_clk_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (clk_raw),
        .lvl_o (clk_s)
    );

    cdr_edge_det #(.N(NCLK), .RST_VAL(CLK_RST)) u_clk_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (clk_s),
        .chg_o (clk_chg)
    );

    assign ser_rise = is_rise(clk_chg.ser, clk_s.ser);
    assign ser_fall = is_fall(clk_chg.ser, clk_s.ser);
    assign reg_rise = is_rise(clk_chg.rgs, clk_s.rgs);
    assign wipe     = ~lvl_s.clr_n;

    cdr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .step    (ser_rise),
        .emit    (ser_fall),
        .din     (lvl_s.din),
        .chain_q (shift_q),
        .dout_q  (ser_dout_o)
    );

    cdr_store_gate #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .load    (reg_rise),
        .blank   (lvl_s.blank),
        .chain_i (shift_q),
        .store_q (store_q),
        .sink_o  (sink_on_o)
    );
endmodule

// File: rtl/chain_drive_reg_chk.sv
module chain_drive_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n_i,
    input logic             blank_i,
    input logic [WIDTH-1:0] sink_on_o,
    input logic             ser_dout_o,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] store_q,
    input logic             ser_rise,
    input logic             ser_fall,
    input logic             reg_rise,
    input logic             wipe
);
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ser_rise) && !$past(wipe)) |-> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])); // R1

    AST_LATCH_PRE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_rise) && !$past(wipe)) |-> store_q == $past(shift_q)); // R7

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_rise) && !$past(wipe)) |-> store_q == $past(store_q)); // R2

    AST_WIPE_ALL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wipe)) |-> (shift_q == '0 && store_q == '0 && !ser_dout_o)); // R3

    AST_CLR_PIN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!clr_n_i && !$past(clr_n_i) && !$past(clr_n_i, 2) && !$past(rst) && !$past(rst, 2))
        |=> (sink_on_o == '0 && !ser_dout_o)); // R3

    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
        (blank_i && $past(blank_i) && $past(blank_i, 2)) |-> sink_on_o == '0); // R4

    AST_DOUT_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ser_dout_o != $past(ser_dout_o)) |-> ($past(ser_fall) || $past(wipe))); // R6
endmodule

bind chain_drive_reg chain_drive_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_n_i    (clr_n_i),
    .blank_i    (blank_i),
    .sink_on_o  (sink_on_o),
    .ser_dout_o (ser_dout_o),
    .shift_q    (shift_q),
    .store_q    (store_q),
    .ser_rise   (ser_rise),
    .ser_fall   (ser_fall),
    .reg_rise   (reg_rise),
    .wipe       (wipe)
);

// File: tb/chain_drive_reg_tb.sv
module chain_drive_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NVEC       = 6;
    localparam int WDOG       = 100000;

    // {blank, first byte, second byte, expected downstream, expected upstream}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
        {1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00},
        {1'b0, 8'h01, 8'h80, 8'h01, 8'h80},
        {1'b1, 8'h5A, 8'hC3, 8'h00, 8'h00},
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'hFF},
        {1'b0, 8'h96, 8'h69, 8'h96, 8'h69}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic reg_clk = 1'b0;
    logic clr_n = 1'b1;
    logic blank = 1'b0;
    logic din = 1'b0;
    logic [W-1:0] up_sink, dn_sink;
    logic up_dout, dn_dout;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_drive_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .reg_clk_i(reg_clk),
        .clr_n_i(clr_n), .blank_i(blank), .ser_din_i(din),
        .sink_on_o(up_sink), .ser_dout_o(up_dout)
    );

    chain_drive_reg #(.WIDTH(W)) u_dn (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .reg_clk_i(reg_clk),
        .clr_n_i(clr_n), .blank_i(blank), .ser_din_i(up_dout),
        .sink_on_o(dn_sink), .ser_dout_o(dn_dout)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        din = b;
        tick(1);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic shift_byte(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) ser_bit(v[i]);
    endtask

    task automatic latch();
        reg_clk = 1'b1;
        tick(4);
        reg_clk = 1'b0;
        tick(4);
    endtask

    task automatic clear_pulse();
        clr_n = 1'b0;
        tick(4);
        clr_n = 1'b1;
        tick(4);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(4);
        // R9 reset state
        check("R9 reset up sink", up_sink, '0);
        check("R9 reset dn sink", dn_sink, '0);
        check("R9 reset dout", {7'd0, up_dout}, '0);

        // table: R1 R2 R5 R8 (chain), R4 (blank row)
        for (int k = 0; k < NVEC; k++) begin
            blank = VEC[k][32];
            shift_byte(VEC[k][31:24]);
            shift_byte(VEC[k][23:16]);
            latch();
            check($sformatf("R1/R5/R8 vec%0d dn", k), dn_sink, VEC[k][15:8]);
            check($sformatf("R2/R4 vec%0d up", k), up_sink, VEC[k][7:0]);
        end

        // R4: blank hides then restores the kept storage (last row 96/69)
        blank = 1'b1;
        tick(4);
        check("R4 blank up", up_sink, '0);
        blank = 1'b0;
        tick(4);
        check("R4 restore up", up_sink, 8'h69);
        check("R5 restore dn", dn_sink, 8'h96);

        // R6 / R8: first bit reaches cascade only on the 8th falling edge
        clear_pulse();
        ser_bit(1'b1);
        for (int i = 0; i < W - 2; i++) ser_bit(1'b0);
        din = 1'b0;
        tick(1);
        ser_clk = 1'b1;
        tick(4);
        check("R6 dout held at rise", {7'd0, up_dout}, '0);
        ser_clk = 1'b0;
        tick(4);
        check("R8 dout after fall", {7'd0, up_dout}, 8'h01);

        // R7: simultaneous serial and register rise
        clear_pulse();
        shift_byte(8'hC3);
        din = 1'b0;
        tick(1);
        ser_clk = 1'b1;
        reg_clk = 1'b1;
        tick(4);
        check("R7 pre-shift capture", up_sink, 8'hC3);
        check("R7 dn pre-shift", dn_sink, 8'h00);
        ser_clk = 1'b0;
        reg_clk = 1'b0;
        tick(4);
        latch();
        check("R1 shifted once", up_sink, 8'h86);
        check("R8 dn got first bit", dn_sink, 8'h01);

        // R3: clear wins over coincident serial and register edges
        clr_n = 1'b0;
        ser_clk = 1'b1;
        reg_clk = 1'b1;
        tick(4);
        check("R3 clear up", up_sink, '0);
        check("R3 clear dn", dn_sink, '0);
        check("R3 clear dout", {7'd0, up_dout}, '0);
        ser_clk = 1'b0;
        reg_clk = 1'b0;
        tick(4);
        clr_n = 1'b1;
        tick(4);
        latch();
        check("R3 chain wiped", up_sink, '0);
        check("R3 dn chain wiped", dn_sink, '0);

        // R9: reset mid-operation
        shift_byte(8'hA5);
        latch();
        check("R2 reload", up_sink, 8'hA5);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(4);
        check("R9 reset clears outputs", up_sink, '0);
        latch();
        check("R9 reset wiped chain", up_sink, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule